// File: doc/BRIEF.md
# Accumulator Machine Control Sequencer

This block is the control unit and datapath of a small accumulator processor. It holds a program counter, a memory address register, a memory buffer register, an instruction register and an accumulator. Every transfer between them passes over one shared internal bus that a multiplexer drives. The block fetches one instruction word at a time from a word-addressed memory, decodes the opcode and executes it as a short chain of register transfers. Each step takes one clock cycle.

The memory port is a fixed-latency synchronous port and has no handshake, so back-pressure cannot occur. The address always comes from the memory address register. A one-cycle read strobe returns its word in the next cycle. A one-cycle write strobe stores the memory buffer register at that address. The input register port is a plain level that the block samples when an input instruction executes. The program counter, the accumulator and a halt flag are brought out as plain status pins.

The fetch overlaps the memory wait cycle with the program counter increment. After a fetch, the program counter already points at the following word. An opcode outside the supported set stops the sequencer until the next reset.

Top module: `acc_cpu_seq`

## Requirements
- R1: While reset is active and at the first clock after it, the program counter, accumulator and halt flag are zero. Both memory strobes are low and the sequencer starts a fetch at word address 0.
- R2: A fetch takes four cycles. The cycle after the address register loads from the program counter asserts the read strobe at that address, and the program counter increments by one in that same cycle. Read data arrives one cycle after the strobe.
- R3: An instruction word carries its opcode in bits 15:12 and an operand address in bits 11:0. Opcode 1 (load) copies the memory word at the operand address into the accumulator and takes 8 cycles, fetch included.
- R4: Opcode 3 (add) sets the accumulator to the accumulator plus the memory word at the operand address, modulo 2^16. It takes 8 cycles.
- R5: Opcode 4 (subtract) sets the accumulator to the accumulator minus the memory word at the operand address, modulo 2^16. It takes 8 cycles.
- R6: Opcode 2 (store) writes the accumulator to the operand address with exactly one write strobe cycle. It takes 7 cycles.
- R7: Opcode 5 (input) copies the input register port into the accumulator. It takes 5 cycles and makes no memory access beyond its fetch.
- R8: Any other opcode (0 and 6 to 15) raises the halt flag 5 cycles after its fetch starts. The flag then stays high until reset. No further memory access happens, and the accumulator and program counter keep their values.
- R9: The read and write strobes are never high together, and each is high for one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Word address, driven from the address register |
| mem_rd | output | 1 | Read strobe; data expected on mem_rdata next cycle |
| mem_wr | output | 1 | Write strobe; mem_wdata stored at mem_addr |
| mem_wdata | output | 16 | Write data from the buffer register |
| mem_rdata | input | 16 | Read data from memory |
| in_data | input | 16 | Input register port |
| acc_out | output | 16 | Accumulator value |
| pc_out | output | 12 | Program counter value |
| halted | output | 1 | High once an unsupported opcode has been decoded |

## Verification
The bench builds the block with its default widths of 16-bit words, 12-bit addresses and 4-bit opcodes. The memory model therefore decodes the full opcode field, and operand addresses can sit well away from the program words. With these values, carries out of bit 15 and borrows below zero are visible in the wrap cases. Opcodes 0 and 15 both reach the halt path. Fetch addresses come out exactly enough to measure the per-instruction cycle counts and the program counter value after halting.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_LOAD  = 1;
  localparam int OPC_STORE = 2;
  localparam int OPC_ADD   = 3;
  localparam int OPC_SUB   = 4;
  localparam int OPC_INPUT = 5;

  typedef enum logic [3:0] {
    ST_F_ADDR, ST_F_WAIT, ST_F_CAP, ST_F_IR, ST_DECODE,
    ST_X_WAIT, ST_X_CAP, ST_X_EXE, ST_S_BUF, ST_S_WR, ST_HALT
  } seq_state_e;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_PC, SRC_IRADDR, SRC_MBR, SRC_AC, SRC_INREG, SRC_MEM, SRC_ALU
  } bus_src_e;

  typedef struct packed {
    bus_src_e src;
    logic     ld_mar;
    logic     ld_mbr;
    logic     ld_ir;
    logic     ld_ac;
    logic     inc_pc;
    logic     rd;
    logic     wr;
    logic     sub;
  } uop_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    if (sub) y = a - b;
    else     y = a + b;
  end
endmodule

// File: rtl/acc_bus_mux.sv
module acc_bus_mux
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  bus_src_e          src,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] ir,
  input  logic [DATA_W-1:0] mbr,
  input  logic [DATA_W-1:0] ac,
  input  logic [DATA_W-1:0] inreg,
  input  logic [DATA_W-1:0] mem,
  input  logic [DATA_W-1:0] alu,
  output logic [DATA_W-1:0] bus
);
  localparam int PAD_W = DATA_W - ADDR_W;

  always_comb begin
    unique case (src)
      SRC_PC:     bus = {{PAD_W{1'b0}}, pc};
      SRC_IRADDR: bus = {{PAD_W{1'b0}}, ir[ADDR_W-1:0]};
      SRC_MBR:    bus = mbr;
      SRC_AC:     bus = ac;
      SRC_INREG:  bus = inreg;
      SRC_MEM:    bus = mem;
      SRC_ALU:    bus = alu;
      default:    bus = '0;
    endcase
  end
endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  output uop_t            uop,
  output logic            halted
);
  localparam logic [OP_W-1:0] K_LOAD  = OP_W'(OPC_LOAD);
  localparam logic [OP_W-1:0] K_STORE = OP_W'(OPC_STORE);
  localparam logic [OP_W-1:0] K_ADD   = OP_W'(OPC_ADD);
  localparam logic [OP_W-1:0] K_SUB   = OP_W'(OPC_SUB);
  localparam logic [OP_W-1:0] K_INPUT = OP_W'(OPC_INPUT);

  seq_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_F_ADDR;
    else        state_q <= state_d;
  end

  always_comb begin
    uop     = '0;
    uop.src = SRC_NONE;
    state_d = state_q;
    unique case (state_q)
      ST_F_ADDR: begin uop.src = SRC_PC;  uop.ld_mar = 1'b1; state_d = ST_F_WAIT; end
      ST_F_WAIT: begin uop.rd = 1'b1; uop.inc_pc = 1'b1;     state_d = ST_F_CAP;  end
      ST_F_CAP:  begin uop.src = SRC_MEM; uop.ld_mbr = 1'b1; state_d = ST_F_IR;   end
      ST_F_IR:   begin uop.src = SRC_MBR; uop.ld_ir  = 1'b1; state_d = ST_DECODE; end
      ST_DECODE: begin
        unique case (opcode)
          K_LOAD, K_ADD, K_SUB: begin
            uop.src = SRC_IRADDR; uop.ld_mar = 1'b1; state_d = ST_X_WAIT;
          end
          K_STORE: begin
            uop.src = SRC_IRADDR; uop.ld_mar = 1'b1; state_d = ST_S_BUF;
          end
          K_INPUT: begin
            uop.src = SRC_INREG; uop.ld_ac = 1'b1; state_d = ST_F_ADDR;
          end
          default: state_d = ST_HALT;
        endcase
      end
      ST_X_WAIT: begin uop.rd = 1'b1; state_d = ST_X_CAP; end
      ST_X_CAP:  begin uop.src = SRC_MEM; uop.ld_mbr = 1'b1; state_d = ST_X_EXE; end
      ST_X_EXE:  begin
        uop.src   = (opcode == K_LOAD) ? SRC_MBR : SRC_ALU;
        uop.sub   = (opcode == K_SUB);
        uop.ld_ac = 1'b1;
        state_d   = ST_F_ADDR;
      end
      ST_S_BUF:  begin uop.src = SRC_AC; uop.ld_mbr = 1'b1; state_d = ST_S_WR; end
      ST_S_WR:   begin uop.wr = 1'b1; state_d = ST_F_ADDR; end
      default:   state_d = ST_HALT;
    endcase
  end

  assign halted = (state_q == ST_HALT);
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] acc_out,
  output logic [ADDR_W-1:0] pc_out,
  output logic              halted
);
  localparam int OPC_LSB = DATA_W - OP_W;

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mbr_q, ir_q, ac_q;
  logic [DATA_W-1:0] bus, alu_y;
  uop_t              uop;

  acc_seq_ctrl #(.OP_W(OP_W)) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (ir_q[DATA_W-1:OPC_LSB]),
    .uop    (uop),
    .halted (halted)
  );

  acc_alu #(.DATA_W(DATA_W)) alu_i (
    .a   (ac_q),
    .b   (mbr_q),
    .sub (uop.sub),
    .y   (alu_y)
  );

  acc_bus_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) bus_i (
    .src   (uop.src),
    .pc    (pc_q),
    .ir    (ir_q),
    .mbr   (mbr_q),
    .ac    (ac_q),
    .inreg (in_data),
    .mem   (mem_rdata),
    .alu   (alu_y),
    .bus   (bus)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      ac_q  <= '0;
    end else begin
      if (uop.inc_pc) pc_q  <= pc_q + ADDR_W'(1);
      if (uop.ld_mar) mar_q <= bus[ADDR_W-1:0];
      if (uop.ld_mbr) mbr_q <= bus;
      if (uop.ld_ir)  ir_q  <= bus;
      if (uop.ld_ac)  ac_q  <= bus;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_rd    = uop.rd;
  assign mem_wr    = uop.wr;
  assign mem_wdata = mbr_q;
  assign acc_out   = ac_q;
  assign pc_out    = pc_q;
endmodule

// File: rtl/acc_cpu_seq_chk.sv
module acc_cpu_seq_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] acc_out,
  input logic [ADDR_W-1:0] pc_out,
  input logic              halted
);
  // R9
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R9
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  // R9
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);
  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));
  // R8
  halt_acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(acc_out) && $stable(pc_out));
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc_out) |-> pc_out == $past(pc_out) + ADDR_W'(1));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (pc_out == '0 && acc_out == '0 && !halted));
endmodule

bind acc_cpu_seq acc_cpu_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .mem_rd  (mem_rd),
  .mem_wr  (mem_wr),
  .acc_out (acc_out),
  .pc_out  (pc_out),
  .halted  (halted)
);

// File: tb/acc_cpu_seq_tb_top.sv
module acc_cpu_seq_tb_top;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam int MEM_N = 4096;
  localparam int NVEC = 7;
  localparam logic [11:0] A_ADDR = 12'h200;
  localparam logic [11:0] B_ADDR = 12'h201;
  localparam logic [11:0] R_ADDR = 12'hFF0;

  typedef struct packed {
    logic [3:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] inv;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd3, 16'h1234, 16'h0FED, 16'h0000},
    '{4'd3, 16'hFFFF, 16'h0001, 16'h0000},
    '{4'd4, 16'h0005, 16'h0007, 16'h0000},
    '{4'd4, 16'h8000, 16'h0001, 16'h0000},
    '{4'd1, 16'hAAAA, 16'h5555, 16'h0000},
    '{4'd5, 16'h0F0F, 16'h0000, 16'hBEEF},
    '{4'd2, 16'h6C6C, 16'h0000, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] in_data = '0;
  logic [DW-1:0] acc_out;
  logic [AW-1:0] pc_out;
  logic          halted;

  logic [DW-1:0] mem [MEM_N];
  int rd_n = 0, wr_n = 0;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  acc_cpu_seq dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .in_data(in_data), .acc_out(acc_out), .pc_out(pc_out), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (rst_n) begin
      if (mem_rd) rd_n <= rd_n + 1;
      if (mem_wr) wr_n <= wr_n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEM_N; i++) mem[i] = 16'h0000;
  endtask

  function automatic int op_cycles(input logic [3:0] op);
    case (op)
      4'd1, 4'd3, 4'd4: return 8;
      4'd2:             return 7;
      4'd5:             return 5;
      default:          return 5;
    endcase
  endfunction

  function automatic logic [15:0] exp_acc(input vec_t v);
    case (v.op)
      4'd3:    return v.a + v.b;
      4'd4:    return v.a - v.b;
      4'd1:    return v.b;
      4'd5:    return v.inv;
      default: return v.a;
    endcase
  endfunction

  task automatic start_run();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt(output int cyc);
    cyc = 0;
    start_run();
    rd_n = 0; wr_n = 0;
    while (!halted && cyc < 400) begin
      @(posedge clk); @(negedge clk);
      cyc++;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int cyc;
    logic [15:0] acc_snap;
    int rd_snap, wr_snap;
    clear_mem();

    // R1 reset state and start of fetch; R2 fetch timing
    mem[0] = 16'h5000;
    mem[1] = 16'hF000;
    start_run();
    check("R1 pc", 32'(pc_out), 0);
    check("R1 acc", 32'(acc_out), 0);
    check("R1 halted", 32'(halted), 0);
    check("R1 strobes", {30'd0, mem_rd, mem_wr}, 0);
    @(posedge clk); @(negedge clk);
    check("R2 read strobe", 32'(mem_rd), 1);
    check("R2 fetch addr", 32'(mem_addr), 0);
    check("R2 pc before inc", 32'(pc_out), 0);
    @(posedge clk); @(negedge clk);
    check("R2 pc incremented", 32'(pc_out), 1);
    check("R2 read one cycle", 32'(mem_rd), 0);

    // Vector table: load a, apply op to b, store result, then halt
    foreach (VECS[k]) begin
      clear_mem();
      mem[0] = {4'd1, A_ADDR};
      mem[1] = {VECS[k].op, (VECS[k].op == 4'd2) ? B_ADDR : B_ADDR};
      mem[2] = {4'd2, R_ADDR};
      mem[3] = 16'h0000;
      mem[A_ADDR] = VECS[k].a;
      mem[B_ADDR] = VECS[k].b;
      in_data = VECS[k].inv;
      run_to_halt(cyc);
      // R3 R4 R5 R7 result in accumulator
      check($sformatf("R3/R4/R5/R7 acc vec%0d", k), 32'(acc_out), 32'(exp_acc(VECS[k])));
      // R6 stored result
      check($sformatf("R6 stored vec%0d", k), 32'(mem[R_ADDR]), 32'(exp_acc(VECS[k])));
      check($sformatf("R6 write count vec%0d", k), wr_n, (VECS[k].op == 4'd2) ? 2 : 1);
      if (VECS[k].op == 4'd2)
        check("R6 store operand", 32'(mem[B_ADDR]), 32'(VECS[k].a));
      // R3 R4 R5 R6 R7 cycle counts
      check($sformatf("R3/R6/R7 cycles vec%0d", k), cyc, 8 + op_cycles(VECS[k].op) + 7 + 5);
      // R7 no extra read for input
      check($sformatf("R7 read count vec%0d", k), rd_n,
            5 + ((VECS[k].op == 4'd1 || VECS[k].op == 4'd3 || VECS[k].op == 4'd4) ? 1 : 0));
      check($sformatf("R8 pc vec%0d", k), 32'(pc_out), 4);
    end

    // R8: undefined opcode 15 at word 0
    clear_mem();
    mem[0] = 16'hFABC;
    run_to_halt(cyc);
    check("R8 halt cycles", cyc, 5);
    check("R8 pc after halt", 32'(pc_out), 1);
    check("R8 acc untouched", 32'(acc_out), 0);

    // R8: halt stays, no access, state kept
    clear_mem();
    mem[0] = 16'h5000;
    mem[1] = 16'h0ABC;
    in_data = 16'h1357;
    run_to_halt(cyc);
    check("R8 cycles after input", cyc, 10);
    acc_snap = acc_out; rd_snap = rd_n; wr_snap = wr_n;
    in_data = 16'h2468;
    repeat (16) @(posedge clk);
    @(negedge clk);
    check("R8 still halted", 32'(halted), 1);
    check("R8 acc held", 32'(acc_out), 32'(acc_snap));
    check("R8 pc held", 32'(pc_out), 2);
    check("R8 no reads", rd_n, rd_snap);
    check("R8 no writes", wr_n, wr_snap);

    // R1: reset clears accumulator after a run
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 acc cleared", 32'(acc_out), 0);
    check("R1 halt cleared", 32'(halted), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule